// File: doc/BRIEF.md
# Sync Period Measurement Counter

This block measures the line and frame timing of an incoming video signal by counting reference oscillator clocks. The horizontal result is the number of clocks spanning two consecutive line-sync periods. The vertical result is the frame-sync period in units of 512 clocks, which is the top 9 bits of a 14-bit counter that advances once every 16 clocks. Each result carries an overflow bit. Counters saturate and do not wrap.

Line and frame sync arrive already synchronized to the oscillator domain. A select input picks the frame-sync source: either a separate frame-sync input or a frame-sync pulse that has been extracted from composite sync. Both sources pass through a two-flop stage and a rising-edge detector. While frame sync is present, the horizontal register is refreshed only once per frame. If no frame-sync edge arrives before the vertical counter saturates, frame sync is treated as absent, and the horizontal register then follows every completed two-line measurement. Firmware reads the registers after a sticky change flag tells it that the timing has moved.

Top module: `sync_period_meter`

## Requirements
- R1: After reset, `hcount_o`, `vcount_o`, both overflow bits and both interrupt flags read 0.
- R2: `hcount_o` holds the exact number of clock cycles between a line-sync rising edge and the second line-sync rising edge after it. For example, a 254-clock line period gives 508.
- R3: When two line periods exceed 2^HCNT_W − 1 clocks, `hcount_o` reads all ones (2047 by default) and `h_ovf_o` is 1.
- R4: While frame sync is present, `hcount_o` changes only in the few cycles that follow a frame-sync rising edge, and it then takes the latest completed measurement.
- R5: While frame sync is absent, `hcount_o` takes each completed horizontal measurement as it finishes. Frame sync is absent after reset, and again whenever the vertical counter saturates before the next frame-sync edge.
- R6: `vcount_o` equals the frame period divided by VDIV·2^(VCNT_W−VOUT_W) clocks, within one LSB. With the default parameters this divisor is 512.
- R7: If the vertical counter saturates, the next frame-sync edge loads `vcount_o` with all ones (511 by default), sets `v_ovf_o` to 1 and raises `v_irq_o`.
- R8: With `vsel_comp_i` = 1, the frame period is taken from `csync_vs_i`. With `vsel_comp_i` = 0, it is taken from `vsync_i`.
- R9: A register update raises its interrupt flag when the new value differs from the old one, when the overflow bit changes, or when an overflow is present. An update that brings identical, non-overflowed data leaves the flag alone.
- R10: The interrupt flags are sticky. A one-cycle `irq_clr_i` pulse clears both of them, but an event in the same cycle wins over the clear.
- R11: `vcount_o` is reloaded on every frame-sync rising edge except the first one after reset. That first edge only starts the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_i | input | 1 | Line sync, active high |
| vsync_i | input | 1 | Separate frame sync, active high |
| csync_vs_i | input | 1 | Frame sync extracted from composite sync |
| vsel_comp_i | input | 1 | 1 selects `csync_vs_i` as the frame source |
| irq_clr_i | input | 1 | One-cycle clear of both interrupt flags |
| hcount_o | output | HCNT_W | Two-line period in clocks |
| h_ovf_o | output | 1 | Horizontal overflow |
| vcount_o | output | VOUT_W | Frame period, upper counter bits |
| v_ovf_o | output | 1 | Vertical overflow |
| h_irq_o | output | 1 | Sticky horizontal change flag |
| v_irq_o | output | 1 | Sticky vertical change flag |

## Verification
The bench targets four corner cases:
- Saturation. A design that wrapped the horizontal counter would report a small residue, not 2047 with the overflow bit set.
- The handover between frame-locked and free-running horizontal updates. A design that latched the horizontal register mid-frame would show changes far from any frame edge. One that never detected frame-sync loss would freeze `hcount_o` after frame sync stops.
- Recovery from a lost frame sync. A design that dropped the overflow would report a plausible but false frame count.
- The interrupt logic. A design that compared against the wrong value, or that raised the flag on every update, would raise `h_irq_o` even when the timing is steady.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int HCNT_W_DEF = 11;
    localparam int VCNT_W_DEF = 14;
    localparam int VOUT_W_DEF = 9;
    localparam int VDIV_DEF   = 16;

    // Progress of a two-line horizontal window.
    typedef enum logic [1:0] {
        HPH_IDLE = 2'd0,   // no line edge seen yet
        HPH_ONE  = 2'd1,   // inside the first line of the window
        HPH_TWO  = 2'd2    // inside the second line of the window
    } hphase_e;

endpackage

// File: rtl/spm_edge_det.sv
// Two-flop (parameterised) synchronizer followed by a rising-edge detector.
module spm_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_i,
    output logic rise_o
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/spm_hmeas.sv
// Counts oscillator clocks across two consecutive line periods.
// The count saturates at all ones and records an overflow.
module spm_hmeas
    import spm_pkg::*;
#(
    parameter int W = HCNT_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_i,
    output logic [W-1:0] meas_o,
    output logic         meas_ovf_o,
    output logic         meas_stb_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        hphase_e      phase;
        logic [W-1:0] cnt;
        logic         ovf;
        logic [W-1:0] meas;
        logic         movf;
        logic         stb;
    } hstate_t;

    hstate_t d, q;

    always_comb begin
        d     = q;
        d.stb = 1'b0;

        // Count while a window is open; hold at the top and flag it.
        if (q.phase != HPH_IDLE) begin
            if (q.cnt == CNT_MAX) d.ovf = 1'b1;
            else                  d.cnt = q.cnt + CNT_ONE;
        end

        if (edge_i) begin
            unique case (q.phase)
                HPH_IDLE: begin
                    d.phase = HPH_ONE;
                    d.cnt   = CNT_ONE;
                    d.ovf   = 1'b0;
                end
                HPH_ONE: begin
                    d.phase = HPH_TWO;
                end
                HPH_TWO: begin
                    d.meas  = q.cnt;
                    d.movf  = q.ovf;
                    d.stb   = 1'b1;
                    d.phase = HPH_ONE;
                    d.cnt   = CNT_ONE;
                    d.ovf   = 1'b0;
                end
                default: begin
                    d.phase = HPH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.phase <= HPH_IDLE;
            q.cnt   <= '0;
            q.ovf   <= 1'b0;
            q.meas  <= '0;
            q.movf  <= 1'b0;
            q.stb   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign meas_o     = q.meas;
    assign meas_ovf_o = q.movf;
    assign meas_stb_o = q.stb;
endmodule

// File: rtl/spm_vmeas.sv
// Frame period counter: a prescaler feeds a saturating CNT_W-bit counter, and
// the upper OUT_W bits are captured on each frame edge. The block also tracks
// whether frame sync is present.
module spm_vmeas
    import spm_pkg::*;
#(
    parameter int CNT_W = VCNT_W_DEF,
    parameter int OUT_W = VOUT_W_DEF,
    parameter int VDIV  = VDIV_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    output logic [OUT_W-1:0] meas_o,
    output logic             meas_ovf_o,
    output logic             meas_stb_o,
    output logic             present_o
);
    localparam int PRE_W = (VDIV > 1) ? $clog2(VDIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(VDIV - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    typedef struct packed {
        logic             armed;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             present;
        logic [OUT_W-1:0] meas;
        logic             movf;
        logic             stb;
    } vstate_t;

    vstate_t d, q;
    logic    tick;

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        tick  = (q.pre == PRE_LAST);

        if (q.armed) begin
            d.pre = tick ? '0 : q.pre + PRE_W'(1);
            if (tick) begin
                if (q.cnt == CNT_MAX) begin
                    d.ovf     = 1'b1;
                    d.present = 1'b0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        end

        if (edge_i) begin
            if (q.armed) begin
                d.meas = q.cnt[CNT_W-1 -: OUT_W];
                d.movf = q.ovf;
                d.stb  = 1'b1;
            end
            d.armed   = 1'b1;
            d.present = 1'b1;
            d.pre     = '0;
            d.cnt     = '0;
            d.ovf     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.armed   <= 1'b0;
            q.pre     <= '0;
            q.cnt     <= '0;
            q.ovf     <= 1'b0;
            q.present <= 1'b0;
            q.meas    <= '0;
            q.movf    <= 1'b0;
            q.stb     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign meas_o     = q.meas;
    assign meas_ovf_o = q.movf;
    assign meas_stb_o = q.stb;
    assign present_o  = q.present;
endmodule

// File: rtl/sync_period_meter.sv
module sync_period_meter
    import spm_pkg::*;
#(
    parameter int HCNT_W      = HCNT_W_DEF,
    parameter int VCNT_W      = VCNT_W_DEF,
    parameter int VOUT_W      = VOUT_W_DEF,
    parameter int VDIV        = VDIV_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_i,
    input  logic              vsync_i,
    input  logic              csync_vs_i,
    input  logic              vsel_comp_i,
    input  logic              irq_clr_i,
    output logic [HCNT_W-1:0] hcount_o,
    output logic              h_ovf_o,
    output logic [VOUT_W-1:0] vcount_o,
    output logic              v_ovf_o,
    output logic              h_irq_o,
    output logic              v_irq_o
);
    localparam int NSRC = 2;   // index 0: line sync, 1: frame sync

    logic [NSRC-1:0] raw_sync;
    logic [NSRC-1:0] rise;
    logic            h_rise, v_rise;

    assign raw_sync = {(vsel_comp_i ? csync_vs_i : vsync_i), hsync_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_edge
        spm_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .din_i  (raw_sync[g]),
            .rise_o (rise[g])
        );
    end

    assign h_rise = rise[0];
    assign v_rise = rise[1];

    logic [HCNT_W-1:0] h_meas;
    logic              h_meas_ovf, h_stb;
    logic [VOUT_W-1:0] v_meas;
    logic              v_meas_ovf, v_stb, v_present;

    spm_hmeas #(.W(HCNT_W)) u_hmeas (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (h_rise),
        .meas_o     (h_meas),
        .meas_ovf_o (h_meas_ovf),
        .meas_stb_o (h_stb)
    );

    spm_vmeas #(.CNT_W(VCNT_W), .OUT_W(VOUT_W), .VDIV(VDIV)) u_vmeas (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (v_rise),
        .meas_o     (v_meas),
        .meas_ovf_o (v_meas_ovf),
        .meas_stb_o (v_stb),
        .present_o  (v_present)
    );

    typedef struct packed {
        logic [HCNT_W-1:0] hcount;
        logic              hovf;
        logic              hhave;
        logic [VOUT_W-1:0] vcount;
        logic              vovf;
        logic              hirq;
        logic              virq;
    } top_state_t;

    top_state_t d, q;
    logic       h_upd, h_evt, v_evt;

    always_comb begin
        d = q;

        if (h_stb) d.hhave = 1'b1;

        // Frame-locked refresh when frame sync is present, free-running otherwise.
        h_upd = v_present ? (v_rise && q.hhave) : h_stb;
        h_evt = h_upd && ((h_meas != q.hcount) || h_meas_ovf || (h_meas_ovf != q.hovf));
        v_evt = v_stb && ((v_meas != q.vcount) || v_meas_ovf || (v_meas_ovf != q.vovf));

        if (h_upd) begin
            d.hcount = h_meas;
            d.hovf   = h_meas_ovf;
        end
        if (v_stb) begin
            d.vcount = v_meas;
            d.vovf   = v_meas_ovf;
        end

        if (h_evt)          d.hirq = 1'b1;
        else if (irq_clr_i) d.hirq = 1'b0;

        if (v_evt)          d.virq = 1'b1;
        else if (irq_clr_i) d.virq = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.hcount <= '0;
            q.hovf   <= 1'b0;
            q.hhave  <= 1'b0;
            q.vcount <= '0;
            q.vovf   <= 1'b0;
            q.hirq   <= 1'b0;
            q.virq   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hcount_o = q.hcount;
    assign h_ovf_o  = q.hovf;
    assign vcount_o = q.vcount;
    assign v_ovf_o  = q.vovf;
    assign h_irq_o  = q.hirq;
    assign v_irq_o  = q.virq;
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
    parameter int HW = 11,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          irq_clr_i,
    input logic [HW-1:0] hcount_o,
    input logic          h_ovf_o,
    input logic [VW-1:0] vcount_o,
    input logic          v_ovf_o,
    input logic          h_irq_o,
    input logic          v_irq_o,
    input logic          v_rise,
    input logic          v_present,
    input logic          v_stb,
    input logic          h_evt,
    input logic          v_evt
);
    p_hsat_r3: assert property (@(posedge clk) disable iff (rst)
        h_ovf_o |-> (hcount_o == {HW{1'b1}}));

    p_vsat_r7: assert property (@(posedge clk) disable iff (rst)
        v_ovf_o |-> (vcount_o == {VW{1'b1}}));

    p_hframe_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (v_present && !v_rise) |=> $stable(hcount_o));

    p_vhold_r11: assert property (@(posedge clk) disable iff (rst)
        !v_stb |=> ($stable(vcount_o) && $stable(v_ovf_o)));

    p_hset_r9: assert property (@(posedge clk) disable iff (rst)
        h_evt |=> h_irq_o);

    p_vset_r9: assert property (@(posedge clk) disable iff (rst)
        v_evt |=> v_irq_o);

    p_hsticky_r10: assert property (@(posedge clk) disable iff (rst)
        (h_irq_o && !irq_clr_i) |=> h_irq_o);

    p_vsticky_r10: assert property (@(posedge clk) disable iff (rst)
        (v_irq_o && !irq_clr_i) |=> v_irq_o);

    p_hclr_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_i && !h_evt) |=> !h_irq_o);

    p_vclr_r10: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_i && !v_evt) |=> !v_irq_o);
endmodule

bind sync_period_meter spm_checker #(.HW(HCNT_W), .VW(VOUT_W)) u_spm_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_clr_i (irq_clr_i),
    .hcount_o  (hcount_o),
    .h_ovf_o   (h_ovf_o),
    .vcount_o  (vcount_o),
    .v_ovf_o   (v_ovf_o),
    .h_irq_o   (h_irq_o),
    .v_irq_o   (v_irq_o),
    .v_rise    (v_rise),
    .v_present (v_present),
    .v_stb     (v_stb),
    .h_evt     (h_evt),
    .v_evt     (v_evt)
);

// File: tb/sync_period_meter_test.sv
module sync_period_meter_test;
    localparam int VDIV = 2;   // frame count = period / (2*32) = period / 64

    // hper, vper, expected hcount, expected h_ovf, expected vcount
    localparam int VEC [4][5] = '{
        '{ 100, 1280,  200, 0,  20},
        '{ 254, 1920,  508, 0,  30},
        '{ 150,  960,  300, 0,  15},
        '{1100, 6400, 2047, 1, 100}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hsync_i = 1'b0, vsync_i = 1'b0, csync_vs_i = 1'b0;
    logic        vsel_comp_i = 1'b0, irq_clr_i = 1'b0;
    logic [10:0] hcount_o;
    logic [8:0]  vcount_o;
    logic        h_ovf_o, v_ovf_o, h_irq_o, v_irq_o;

    always #2 clk = ~clk;

    sync_period_meter #(.VDIV(VDIV)) uut (
        .clk(clk), .rst(rst), .hsync_i(hsync_i), .vsync_i(vsync_i),
        .csync_vs_i(csync_vs_i), .vsel_comp_i(vsel_comp_i), .irq_clr_i(irq_clr_i),
        .hcount_o(hcount_o), .h_ovf_o(h_ovf_o), .vcount_o(vcount_o), .v_ovf_o(v_ovf_o),
        .h_irq_o(h_irq_o), .v_irq_o(v_irq_o)
    );

    int checks = 0, fails = 0;
    int hper = 100, vper = 1280;
    bit h_en = 0, v_en = 0, route = 0, mon_en = 0;
    int hc = 0, vc = 0, viol = 0;
    logic [10:0] prev_h = '0;

    // Sync generators and frame-lock monitor, all on the falling edge.
    always @(negedge clk) begin
        if (hc + 1 >= hper) hc = 0; else hc++;
        if (vc + 1 >= vper) vc = 0; else vc++;
        hsync_i    <= h_en && (hc < 4);
        vsync_i    <= v_en && !route && (vc < 8);
        csync_vs_i <= v_en && route && (vc < 8);
        if (mon_en && (hcount_o != prev_h) && (vc > 12)) viol++;
        prev_h = hcount_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_tol(input string req, input int act, input int exp);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d(+-1)", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 irq_clr_i = 1'b1;
        @(posedge clk); #1 irq_clr_i = 1'b0;
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R1: reset state
        chk("R1 hcount", hcount_o, 0);
        chk("R1 vcount", vcount_o, 0);
        chk("R1 h_ovf", h_ovf_o, 0);
        chk("R1 v_ovf", v_ovf_o, 0);
        chk("R1 h_irq", h_irq_o, 0);
        chk("R1 v_irq", v_irq_o, 0);

        h_en = 1; v_en = 1;
        // R2, R3, R6: table of periods
        for (int i = 0; i < 4; i++) begin
            hper = VEC[i][0];
            vper = VEC[i][1];
            wait_cyc(4 * VEC[i][1]);
            chk("R2/R3 hcount", hcount_o, VEC[i][2]);
            chk("R3 h_ovf", h_ovf_o, VEC[i][3]);
            chk_tol("R6 vcount", vcount_o, VEC[i][4]);
            chk("R6 v_ovf", v_ovf_o, 0);
        end

        // R9, R10, R4: steady timing raises nothing, then a change does
        hper = 100; vper = 1280;
        wait_cyc(5 * 1280);
        mon_en = 1;
        pulse_clr();
        wait_cyc(3 * 1280);
        chk("R9 h_irq steady", h_irq_o, 0);
        chk("R9 v_irq steady", v_irq_o, 0);
        chk("R2 hcount steady", hcount_o, 200);
        hper = 120;
        wait_cyc(3 * 1280);
        chk("R4 hcount new", hcount_o, 240);
        chk("R9 h_irq change", h_irq_o, 1);
        chk("R9 v_irq unchanged", v_irq_o, 0);
        chk("R10 h_irq sticky", h_irq_o, 1);
        pulse_clr();
        wait_cyc(2);
        chk("R10 h_irq cleared", h_irq_o, 0);
        mon_en = 0;
        chk("R4 hcount changes away from frame edge", viol, 0);

        // R5: frame sync absent, horizontal register free-runs
        v_en = 0;
        wait_cyc(70000);
        hper = 130;
        wait_cyc(2000);
        chk("R5 hcount free-run", hcount_o, 260);
        pulse_clr();
        wait_cyc(2);

        // R7, R11: frame sync returns after the counter saturated
        @(posedge clk); #1;
        vper = 1280; vc = 1279; v_en = 1;
        wait_cyc(40);
        chk("R7 vcount saturated", vcount_o, 511);
        chk("R7 v_ovf", v_ovf_o, 1);
        chk("R7 v_irq", v_irq_o, 1);
        wait_cyc(3 * 1280);
        chk_tol("R11 vcount recovered", vcount_o, 20);
        chk("R11 v_ovf cleared", v_ovf_o, 0);
        chk("R4 hcount relocked", hcount_o, 260);

        // R8: composite frame source
        route = 1; vsel_comp_i = 1'b1; vper = 1920;
        wait_cyc(4 * 1920);
        chk_tol("R8 composite vcount", vcount_o, 30);
        chk("R8 composite v_ovf", v_ovf_o, 0);

        report();
    end
endmodule